// File: doc/BRIEF.md
# Rolling-Key Output Lock

This block guards the result outputs of a protected core in functional mode. The flip-flops that serve as dummy scan cells in test mode are reused as a key register. The key is shifted in one bit at a time from the serial key input. At the start of every processing iteration, the block compares this register with a key that an internal 128-bit linear feedback shift register has just produced. The expected key moves on by 128 generator steps each iteration, so a key that unlocked one iteration does not unlock the next.

When the comparison succeeds, the core's result word passes straight through. When it fails, a pseudo-random stream replaces the result, so a locked part still produces data that changes every cycle. That stream runs one generator step per clock. Each time the core reports a result as ready, the stream restarts from the most recently generated key. In functional mode the block also forces the scan-multiplexer select to pass logic data. In test mode it passes the external scan-enable through and freezes its own lock state.

Top module: `rolling_lock`

## Requirements
- R1: Synchronous active-low reset leaves `unlocked` low, and leaves the substitute stream at the seed value, with a zero `SEED` parameter replaced by the constant 1.
- R2: `scan_sel` is 1 whenever `test_mode` is 0, and equals `scan_en` whenever `test_mode` is 1.
- R3: While `test_mode` is 0 and `key_en` is 1, the key register shifts left by one bit per clock, taking `key_bit` into bit 0. The first bit sent therefore lands in bit 127 after 128 shifts (MSB first).
- R4: The expected key for the first iteration after reset is the seed advanced by 128 generator steps. Each accepted `load` moves the expected key on by a further 128 steps.
- R5: On an accepted `load`, `unlocked` becomes 1 in the next cycle if the key register equals the expected key, and 0 otherwise. The key register value used is the one held before that edge. `unlocked` keeps this value until the next accepted `load`.
- R6: While `unlocked` is 1, `dout` equals `core_data` in the same cycle.
- R7: While `unlocked` is 0, `dout` equals the low 32 bits of the substitute stream. Each clock that has no reseed advances the stream by one Fibonacci step: shift left, with the new bit 0 being the XOR of bits 127, 28, 26 and 1 (polynomial x^128+x^29+x^27+x^2+1).
- R8: An accepted `ready` loads the stream with the expected key as it stood before that edge, including when `load` is accepted in the same cycle.
- R9: A zero seed is replaced by 1, so the stream and the keys never become all-zero.
- R10: While `test_mode` is 1, `load`, `ready` and `key_en` have no effect. `unlocked`, the key register and the expected key all hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | 1 = scan test, 0 = functional |
| scan_en | input | 1 | External scan-enable, used in test mode |
| scan_sel | output | 1 | Select line for the scan multiplexers |
| key_en | input | 1 | Serial key shift enable |
| key_bit | input | 1 | Serial key data (first scan input) |
| load | input | 1 | Iteration start pulse; samples the comparison |
| ready | input | 1 | Core result ready; reseeds the stream |
| core_data | input | 32 | Result word from the protected core |
| dout | output | 32 | Guarded result word |
| unlocked | output | 1 | 1 when the current iteration's key matched |

## Verification
The hardest state to reach from the ports is a correct unlock several iterations deep. The key needed then is the seed pushed through many multiples of 128 generator steps, and it exists nowhere outside the block. The bench keeps its own model of the key sequence and shifts the exact expected key in serially, sometimes with idle gaps. In random iterations it flips one random bit of that key, so that matching and mismatching iterations alternate unpredictably. Separate directed cases cover three more situations: a reseed coinciding with a load, key traffic sent during test mode, and a second instance built with a zero seed.

// File: rtl/rl_pkg.sv
// Package: shared constants and generator step functions for the rolling lock.
// Assumes a 128-bit Fibonacci LFSR with taps 128, 29, 27, 2.
package rl_pkg;
    localparam int KEY_W     = 128;
    localparam int ITER_STEP = 128;
    localparam logic [KEY_W-1:0] ZERO_SUB = 128'h1;

    // One Fibonacci step: shift left, feedback into bit 0
    function automatic logic [KEY_W-1:0] lfsr_step(input logic [KEY_W-1:0] s);
        logic fb;
        fb = s[127] ^ s[28] ^ s[26] ^ s[1];
        return {s[KEY_W-2:0], fb};
    endfunction

    // Advance the generator by one full iteration
    function automatic logic [KEY_W-1:0] lfsr_iter(input logic [KEY_W-1:0] s);
        logic [KEY_W-1:0] t;
        t = s;
        for (int i = 0; i < ITER_STEP; i++) t = lfsr_step(t);
        return t;
    endfunction

    // Replace an all-zero seed by a nonzero constant
    function automatic logic [KEY_W-1:0] fix_seed(input logic [KEY_W-1:0] s);
        return (s == '0) ? ZERO_SUB : s;
    endfunction
endpackage

// File: rtl/rl_key_shift.sv
// Key register: the dummy scan cells reused as a serial-in shift register.
// Assumes the caller gates the enable with functional mode; MSB-first loading.
module rl_key_shift #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] key_q
);
    // Shift one bit per enabled clock into bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)        key_q <= '0;
        else if (shift_en) key_q <= {key_q[W-2:0], din};
    end

    p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (key_q[0] == $past(din)) && (key_q[W-1:1] == $past(key_q[W-2:0])));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(key_q));
endmodule

// File: rtl/rl_prbs.sv
// Generator: holds the expected key (advanced one iteration per accepted load)
// and a per-clock substitute stream reseeded from the key on an accepted ready.
// Assumes the caller has already gated advance/reseed with functional mode.
module rl_prbs
    import rl_pkg::*;
#(
    parameter logic [KEY_W-1:0] SEED = 128'h1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             reseed,
    output logic [KEY_W-1:0] key_q,
    output logic [KEY_W-1:0] stream_q
);
    localparam logic [KEY_W-1:0] SEED_OK = fix_seed(SEED);
    localparam logic [KEY_W-1:0] KEY0    = lfsr_iter(SEED_OK);

    logic [KEY_W-1:0] key_next;

    // Next iteration's key, 128 steps ahead
    always_comb key_next = lfsr_iter(key_q);

    // Expected key register
    always_ff @(posedge clk) begin
        if (!rst_n)       key_q <= KEY0;
        else if (advance) key_q <= key_next;
    end

    // Substitute stream: one step per clock, or reload from the key
    always_ff @(posedge clk) begin
        if (!rst_n)      stream_q <= SEED_OK;
        else if (reseed) stream_q <= key_q;
        else             stream_q <= lfsr_step(stream_q);
    end

    p_key_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(key_q));
    p_reseed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reseed |=> stream_q == $past(key_q));
    p_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (key_q != '0) && (stream_q != '0));
endmodule

// File: rtl/rl_match.sv
// Comparator: samples key-register equality on an accepted load and holds it.
// Assumes the sample strobe is already gated with functional mode.
module rl_match #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample,
    input  logic [W-1:0] got_key,
    input  logic [W-1:0] exp_key,
    output logic         unlocked
);
    // Lock flag, locked after reset
    always_ff @(posedge clk) begin
        if (!rst_n)      unlocked <= 1'b0;
        else if (sample) unlocked <= (got_key == exp_key);
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sample |=> $stable(unlocked));
    p_bad_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && (got_key != exp_key)) |=> !unlocked);
endmodule

// File: rtl/rolling_lock.sv
// Top: rolling-key lock on a core's result word. In functional mode it forces
// the scan select high, shifts the serial key, checks it each iteration and
// chooses between core data and the pseudo-random substitute. In test mode
// the lock state is frozen and the external scan-enable is passed through.
module rolling_lock
    import rl_pkg::*;
#(
    parameter int               DATA_W = 32,
    parameter logic [KEY_W-1:0] SEED   = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_mode,
    input  logic              scan_en,
    output logic              scan_sel,
    input  logic              key_en,
    input  logic              key_bit,
    input  logic              load,
    input  logic              ready,
    input  logic [DATA_W-1:0] core_data,
    output logic [DATA_W-1:0] dout,
    output logic              unlocked
);
    logic             func;
    logic [KEY_W-1:0] got_key;
    logic [KEY_W-1:0] exp_key;
    logic [KEY_W-1:0] stream;

    // Functional-mode gating of all lock controls
    always_comb func = !test_mode;

    // Scan multiplexer select: logic data in functional mode
    always_comb scan_sel = func ? 1'b1 : scan_en;

    rl_key_shift #(.W(KEY_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(key_en && func),
        .din(key_bit), .key_q(got_key));

    rl_prbs #(.SEED(SEED)) u_prbs (
        .clk(clk), .rst_n(rst_n), .advance(load && func),
        .reseed(ready && func), .key_q(exp_key), .stream_q(stream));

    rl_match #(.W(KEY_W)) u_match (
        .clk(clk), .rst_n(rst_n), .sample(load && func),
        .got_key(got_key), .exp_key(exp_key), .unlocked(unlocked));

    // Output selection: core result when unlocked, substitute otherwise
    always_comb dout = unlocked ? core_data : stream[DATA_W-1:0];

    p_scan_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> scan_sel);
    p_mux_r6: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |-> dout == core_data);
    p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |=> $stable(unlocked));
endmodule

// File: tb/sim_rolling_lock.sv
module sim_rolling_lock;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         test_mode = 1'b0, scan_en = 1'b0;
    logic         key_en = 1'b0, key_bit = 1'b0, load = 1'b0, ready = 1'b0;
    logic [31:0]  core_data = '0;
    logic [31:0]  dout, dout1;
    logic         scan_sel, scan_sel1, unlocked, unlocked1;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // model state
    logic [127:0] m_sh, m_key, m_str, m1_str;
    logic         m_unl;

    localparam logic [127:0] SEED_A = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;

    always #10 clk = ~clk;

    rolling_lock u0 (.clk(clk), .rst_n(rst_n), .test_mode(test_mode), .scan_en(scan_en),
        .scan_sel(scan_sel), .key_en(key_en), .key_bit(key_bit), .load(load),
        .ready(ready), .core_data(core_data), .dout(dout), .unlocked(unlocked));

    rolling_lock #(.SEED(128'h0)) u1 (.clk(clk), .rst_n(rst_n), .test_mode(1'b1),
        .scan_en(scan_en), .scan_sel(scan_sel1), .key_en(key_en), .key_bit(key_bit),
        .load(load), .ready(ready), .core_data(core_data), .dout(dout1),
        .unlocked(unlocked1));

    function automatic logic [127:0] f_step(input logic [127:0] s);
        return {s[126:0], s[127] ^ s[28] ^ s[26] ^ s[1]};
    endfunction

    function automatic logic [127:0] f_iter(input logic [127:0] s);
        logic [127:0] t = s;
        for (int i = 0; i < 128; i++) t = f_step(t);
        return t;
    endfunction

    // Reference model, updated from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sh <= '0; m_key <= f_iter(SEED_A); m_str <= SEED_A; m_unl <= 1'b0;
            m1_str <= 128'h1;
        end else begin
            m1_str <= f_step(m1_str);
            if (!test_mode && key_en) m_sh <= {m_sh[126:0], key_bit};
            if (!test_mode && load) begin
                m_unl <= (m_sh == m_key);
                m_key <= f_iter(m_key);
            end
            m_str <= (!test_mode && ready) ? m_key : f_step(m_str);
        end
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    task automatic cycle_checks();
        if (!rst_n) return;
        chk("R5", {127'd0, unlocked}, {127'd0, m_unl});
        if (m_unl) chk("R6", {96'd0, dout}, {96'd0, core_data});
        else       chk("R7", {96'd0, dout}, {96'd0, m_str[31:0]});
        chk("R2", {127'd0, scan_sel}, {127'd0, test_mode ? scan_en : 1'b1});
        chk("R9", {96'd0, dout1}, {96'd0, m1_str[31:0]});
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cycle_checks();
        core_data = $urandom;
        scan_en = $urandom;
    endtask

    task automatic send_key(input logic [127:0] k, input bit gaps);
        for (int i = 127; i >= 0; i--) begin
            key_en = 1'b1; key_bit = k[i];
            tick();
            if (gaps && ($urandom % 4 == 0)) begin
                key_en = 1'b0; key_bit = $urandom;
                tick();
            end
        end
        key_en = 1'b0;
    endtask

    task automatic pulse_load();
        load = 1'b1; tick(); load = 1'b0;
    endtask

    initial begin
        logic [127:0] saved;
        void'($urandom(32'd1234));
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1", {127'd0, unlocked}, 128'd0);
        chk("R1", {96'd0, dout}, {96'd0, f_step(SEED_A)[31:0]});
        chk("R9", {96'd0, dout1}, {96'd0, f_step(128'h1)[31:0]});

        // R3/R4 first key, sent MSB first
        send_key(f_iter(SEED_A), 1'b0);
        pulse_load();
        chk("R4", {127'd0, unlocked}, 128'd1);
        repeat (3) tick();
        chk("R5", {127'd0, unlocked}, 128'd1);

        // R4 same key again no longer valid
        pulse_load();
        chk("R4", {127'd0, unlocked}, 128'd0);

        // R3 shift order: wrong bit order must fail
        saved = m_key;
        send_key({<<{saved}}, 1'b0);
        pulse_load();
        chk("R3", {127'd0, unlocked}, {127'd0, ({<<{saved}} == saved)});

        // R8 ready alone while locked
        saved = m_key;
        ready = 1'b1; tick(); ready = 1'b0;
        chk("R8", {96'd0, dout}, {96'd0, saved[31:0]});

        // R8 ready with load in the same cycle (wrong key keeps it locked)
        saved = m_key;
        load = 1'b1; ready = 1'b1; tick(); load = 1'b0; ready = 1'b0;
        chk("R8", {96'd0, dout}, {96'd0, saved[31:0]});

        // R10 unlock, then test-mode traffic must not disturb it
        send_key(m_key, 1'b1);
        pulse_load();
        chk("R5", {127'd0, unlocked}, 128'd1);
        saved = m_key;
        test_mode = 1'b1;
        for (int i = 0; i < 10; i++) begin key_en = 1'b1; key_bit = $urandom; tick(); end
        key_en = 1'b0;
        load = 1'b1; ready = 1'b1; tick(); load = 1'b0; ready = 1'b0;
        chk("R10", {127'd0, unlocked}, 128'd1);
        chk("R2", {127'd0, scan_sel}, {127'd0, scan_en});
        test_mode = 1'b0;
        tick();
        send_key(saved, 1'b0);
        pulse_load();
        chk("R10", {127'd0, unlocked}, 128'd1);

        // Random iterations: correct or single-bit-corrupted keys
        for (int it = 0; it < 40; it++) begin
            bit good;
            logic [127:0] k;
            good = $urandom % 2;
            k = m_key;
            if (!good) k[$urandom % 128] ^= 1'b1;
            send_key(k, 1'b1);
            if ($urandom % 3 == 0) begin ready = 1'b1; tick(); ready = 1'b0; end
            pulse_load();
            chk("R5", {127'd0, unlocked}, {127'd0, good});
            repeat ($urandom % 5) tick();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule